// File: doc/BRIEF.md
# Replicated-Register Steering Target Lookup

This block classifies an incoming register address for a fabric in which one address may name several physical copies of a register, spread over groups and instances of hardware units. On each address strobe it decides whether the address is replicated and, if it is, which group/instance pair the access should be steered to so that it reaches a copy that is present and not fused off. Several steering kinds are held. Each kind has a short list of inclusive address windows and a target pair derived from fuse masks. A separate implicit list marks addresses whose steering is set once at bring-up and needs no per-access steering.

Window contents arrive on flat configuration ports. The targets are derived combinationally from fuse-enable masks by a helper stage, and the masks are expected to be stable while lookups run. The result (steer flag, group, instance, warning) is registered and appears one cycle after the strobe, with a result-valid pulse. The kinds are searched in a fixed order: l3-bank (index 0), memory-slice (1), cache-fabric (2), subslice (3), node (4).

Top module: `repl_steer_lookup`

## Requirements
- R1: During and right after reset, res_valid_o, steer_o, group_o, inst_o and warn_o are all 0.
- R2: A strobe on addr_valid_i at a clock edge produces a res_valid_o pulse in the following cycle, carrying the result for that address. res_valid_o never rises without such a strobe, and back-to-back strobes give back-to-back results.
- R3: A window matches an address A when start <= A <= end. Both bounds are inclusive, and a window whose start equals its end matches exactly that one address.
- R4: Within a kind's list (and the implicit list), window e is live only if every window 0..e has a nonzero end. Windows after the first zero-end entry never match.
- R5: When several kinds match, the kind with the lowest index supplies the target, with steer_o=1 and warn_o=0.
- R6: An address that matches no usable explicit kind but lies in an implicit window gives steer_o=0, warn_o=0, group_o=0 and inst_o=0.
- R7: An explicit match takes precedence over an implicit window that covers the same address.
- R8: An address in no list gives steer_o=1, group_o=0, inst_o=0 and warn_o=1.
- R9: A kind whose fuse mask is all zero has no usable target and never produces a match. Its windows are then treated as absent.
- R10: Subslice target: with i the lowest set bit of sub_en_i, group=i/4 and instance=i%4. When WIDE_SUB=1, group=i/8 and instance=i%8.
- R11: Memory-slice target: group is the lowest set bit m of mslice_en_i, and instance is 0. Cache-fabric target: group=2*m, instance 0.
- R12: L3-bank target: group=m, the lowest set bit of mslice_en_i. The instance is 0 when bank_mask_i[0]=1 and 2 otherwise.
- R13: Node target: with s the lowest set bit of node_en_i, group=s>>1 and instance=s[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_valid_i | input | 1 | Lookup strobe |
| addr_i | input | ADDR_W (24) | Address to classify |
| cfg_start_i | input | 5*RNG_N*ADDR_W (480) | Window start per kind k, entry e, at bit ((k*RNG_N)+e)*ADDR_W |
| cfg_end_i | input | 5*RNG_N*ADDR_W (480) | Window end, same layout; zero end terminates a list |
| imp_start_i | input | IMP_N*ADDR_W (96) | Implicit window start, entry e at bit e*ADDR_W |
| imp_end_i | input | IMP_N*ADDR_W (96) | Implicit window end |
| mslice_en_i | input | MSL_W (4) | Memory-slice enable mask |
| bank_mask_i | input | BANK_W (3) | L3 bank mask |
| sub_en_i | input | SUB_W (16) | Enabled-subslice mask |
| node_en_i | input | NODE_W (8) | Node enable mask |
| res_valid_o | output | 1 | Result valid pulse |
| steer_o | output | 1 | Steering required |
| group_o | output | GRP_W (4) | Group target |
| inst_o | output | INST_W (4) | Instance target |
| warn_o | output | 1 | Address found in no list |

## Verification
The assertions check, on every cycle, the one-cycle latency between strobe and result and the consistency of the output fields. A warning must carry a zero target with steer set, and an implicit result must be all zero and silent. They also check the shape of the derived targets: the cache-fabric group is twice the memory-slice group, and the l3-bank instance is only 0 or 2. Only the bench scenarios can show the behaviour that depends on window contents and fuse values. This covers the inclusive bounds, the zero-end terminator, priority between overlapping kinds, explicit-over-implicit precedence, the skipping of a kind with an empty mask, and the exact target arithmetic for each kind.

// File: rtl/repl_steer_pkg.sv
package repl_steer_pkg;

   // Search order of the steering kinds; lower index wins.
   typedef enum int unsigned {
      SK_L3BANK = 0,
      SK_MSLICE = 1,
      SK_FABRIC = 2,
      SK_SUBSL  = 3,
      SK_NODE   = 4
   } steer_kind_e;

   localparam int unsigned NUM_KINDS = 5;
   localparam int unsigned MASK_MAX  = 64;

   // Index of the lowest set bit; 0 for an empty mask.
   function automatic int unsigned low_bit(input logic [MASK_MAX-1:0] m);
      int unsigned r;
      r = 0;
      for (int i = MASK_MAX - 1; i >= 0; i--) begin
         if (m[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/steer_window_match.sv
module steer_window_match #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned N_WIN  = 4
) (
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [N_WIN*ADDR_W-1:0] lo_i,
   input  logic [N_WIN*ADDR_W-1:0] hi_i,
   output logic                    hit_o
);

   if (N_WIN < 1) begin : g_bad_n
      $error("steer_window_match: N_WIN must be at least 1");
   end

   logic [N_WIN-1:0] live;
   logic [N_WIN-1:0] in_win;

   // A window is live only while no earlier window has a zero end.
   always_comb begin
      logic still;
      still = 1'b1;
      for (int e = 0; e < N_WIN; e++) begin
         still   = still & (hi_i[e*ADDR_W +: ADDR_W] != '0);
         live[e] = still;
      end
   end

   for (genvar e = 0; e < N_WIN; e++) begin : g_win
      assign in_win[e] = (addr_i >= lo_i[e*ADDR_W +: ADDR_W]) &&
                         (addr_i <= hi_i[e*ADDR_W +: ADDR_W]);
   end

   assign hit_o = |(live & in_win);

endmodule

// File: rtl/steer_target_gen.sv
module steer_target_gen
   import repl_steer_pkg::*;
#(
   parameter int unsigned MSL_W    = 4,
   parameter int unsigned BANK_W   = 3,
   parameter int unsigned SUB_W    = 16,
   parameter int unsigned NODE_W   = 8,
   parameter int unsigned GRP_W    = 4,
   parameter int unsigned INST_W   = 4,
   parameter bit          WIDE_SUB = 1'b0
) (
   input  logic [MSL_W-1:0]            mslice_en_i,
   input  logic [BANK_W-1:0]           bank_mask_i,
   input  logic [SUB_W-1:0]            sub_en_i,
   input  logic [NODE_W-1:0]           node_en_i,
   output logic [NUM_KINDS-1:0]        tgt_ok_o,
   output logic [NUM_KINDS*GRP_W-1:0]  tgt_grp_o,
   output logic [NUM_KINDS*INST_W-1:0] tgt_inst_o
);

   localparam int unsigned SUB_SH = WIDE_SUB ? 3 : 2;

   if (MSL_W > MASK_MAX || SUB_W > MASK_MAX || NODE_W > MASK_MAX) begin : g_bad_mask
      $error("steer_target_gen: a fuse mask is wider than MASK_MAX");
   end
   if (INST_W < SUB_SH) begin : g_bad_inst
      $error("steer_target_gen: INST_W too narrow for the subslice remainder");
   end
   if (INST_W < 2) begin : g_bad_inst2
      $error("steer_target_gen: INST_W must hold bank index 2");
   end

   int unsigned msl_idx, sub_idx, node_idx;
   logic [INST_W-1:0] sub_inst;
   logic [GRP_W-1:0]  sub_grp;

   always_comb begin
      msl_idx  = low_bit(MASK_MAX'(mslice_en_i));
      sub_idx  = low_bit(MASK_MAX'(sub_en_i));
      node_idx = low_bit(MASK_MAX'(node_en_i));
   end

   // Subslice split: the width of the per-group field is a variant choice.
   if (WIDE_SUB) begin : g_sub_wide
      assign sub_grp  = GRP_W'(sub_idx >> 3);
      assign sub_inst = INST_W'(sub_idx & 32'd7);
   end else begin : g_sub_narrow
      assign sub_grp  = GRP_W'(sub_idx >> 2);
      assign sub_inst = INST_W'(sub_idx & 32'd3);
   end

   always_comb begin
      tgt_ok_o   = '0;
      tgt_grp_o  = '0;
      tgt_inst_o = '0;

      tgt_ok_o[SK_L3BANK]                   = |mslice_en_i;
      tgt_grp_o[SK_L3BANK*GRP_W +: GRP_W]   = GRP_W'(msl_idx);
      tgt_inst_o[SK_L3BANK*INST_W +: INST_W] = bank_mask_i[0] ? INST_W'(0) : INST_W'(2);

      tgt_ok_o[SK_MSLICE]                   = |mslice_en_i;
      tgt_grp_o[SK_MSLICE*GRP_W +: GRP_W]   = GRP_W'(msl_idx);

      tgt_ok_o[SK_FABRIC]                   = |mslice_en_i;
      tgt_grp_o[SK_FABRIC*GRP_W +: GRP_W]   = GRP_W'(msl_idx << 1);

      tgt_ok_o[SK_SUBSL]                    = |sub_en_i;
      tgt_grp_o[SK_SUBSL*GRP_W +: GRP_W]    = sub_grp;
      tgt_inst_o[SK_SUBSL*INST_W +: INST_W] = sub_inst;

      tgt_ok_o[SK_NODE]                     = |node_en_i;
      tgt_grp_o[SK_NODE*GRP_W +: GRP_W]     = GRP_W'(node_idx >> 1);
      tgt_inst_o[SK_NODE*INST_W +: INST_W]  = INST_W'(node_idx & 32'd1);
   end

endmodule

// File: rtl/repl_steer_lookup.sv
module repl_steer_lookup
   import repl_steer_pkg::*;
#(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned RNG_N    = 4,
   parameter int unsigned IMP_N    = 4,
   parameter int unsigned MSL_W    = 4,
   parameter int unsigned BANK_W   = 3,
   parameter int unsigned SUB_W    = 16,
   parameter int unsigned NODE_W   = 8,
   parameter int unsigned GRP_W    = 4,
   parameter int unsigned INST_W   = 4,
   parameter bit          WIDE_SUB = 1'b0
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              addr_valid_i,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic [NUM_KINDS*RNG_N*ADDR_W-1:0] cfg_start_i,
   input  logic [NUM_KINDS*RNG_N*ADDR_W-1:0] cfg_end_i,
   input  logic [IMP_N*ADDR_W-1:0]           imp_start_i,
   input  logic [IMP_N*ADDR_W-1:0]           imp_end_i,
   input  logic [MSL_W-1:0]                  mslice_en_i,
   input  logic [BANK_W-1:0]                 bank_mask_i,
   input  logic [SUB_W-1:0]                  sub_en_i,
   input  logic [NODE_W-1:0]                 node_en_i,
   output logic                              res_valid_o,
   output logic                              steer_o,
   output logic [GRP_W-1:0]                  group_o,
   output logic [INST_W-1:0]                 inst_o,
   output logic                              warn_o
);

   localparam int unsigned KIND_BITS = RNG_N * ADDR_W;

   if (GRP_W < $clog2(MSL_W) + 1) begin : g_bad_grp
      $error("repl_steer_lookup: GRP_W cannot hold the cache-fabric group");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("repl_steer_lookup: ADDR_W too small");
   end

   logic [NUM_KINDS-1:0]        tgt_ok;
   logic [NUM_KINDS*GRP_W-1:0]  tgt_grp;
   logic [NUM_KINDS*INST_W-1:0] tgt_inst;
   logic [NUM_KINDS-1:0]        kind_hit;
   logic                        imp_hit;

   steer_target_gen #(
      .MSL_W(MSL_W), .BANK_W(BANK_W), .SUB_W(SUB_W), .NODE_W(NODE_W),
      .GRP_W(GRP_W), .INST_W(INST_W), .WIDE_SUB(WIDE_SUB)
   ) u_tgt (
      .mslice_en_i (mslice_en_i),
      .bank_mask_i (bank_mask_i),
      .sub_en_i    (sub_en_i),
      .node_en_i   (node_en_i),
      .tgt_ok_o    (tgt_ok),
      .tgt_grp_o   (tgt_grp),
      .tgt_inst_o  (tgt_inst)
   );

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      steer_window_match #(.ADDR_W(ADDR_W), .N_WIN(RNG_N)) u_win (
         .addr_i (addr_i),
         .lo_i   (cfg_start_i[k*KIND_BITS +: KIND_BITS]),
         .hi_i   (cfg_end_i[k*KIND_BITS +: KIND_BITS]),
         .hit_o  (kind_hit[k])
      );
   end

   steer_window_match #(.ADDR_W(ADDR_W), .N_WIN(IMP_N)) u_imp (
      .addr_i (addr_i),
      .lo_i   (imp_start_i),
      .hi_i   (imp_end_i),
      .hit_o  (imp_hit)
   );

   // Priority pick: scan downwards so the lowest usable kind is written last.
   logic              nx_steer, nx_warn;
   logic [GRP_W-1:0]  nx_grp;
   logic [INST_W-1:0] nx_inst;

   always_comb begin
      logic found;
      found   = 1'b0;
      nx_grp  = '0;
      nx_inst = '0;
      for (int k = NUM_KINDS - 1; k >= 0; k--) begin
         if (kind_hit[k] && tgt_ok[k]) begin
            found   = 1'b1;
            nx_grp  = tgt_grp[k*GRP_W +: GRP_W];
            nx_inst = tgt_inst[k*INST_W +: INST_W];
         end
      end
      nx_steer = found | ~imp_hit;
      nx_warn  = ~found & ~imp_hit;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         res_valid_o <= 1'b0;
         steer_o     <= 1'b0;
         group_o     <= '0;
         inst_o      <= '0;
         warn_o      <= 1'b0;
      end else begin
         res_valid_o <= addr_valid_i;
         if (addr_valid_i) begin
            steer_o <= nx_steer;
            group_o <= nx_grp;
            inst_o  <= nx_inst;
            warn_o  <= nx_warn;
         end
      end
   end

   p_result_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_valid_i |=> res_valid_o);

   p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_valid_o |-> $past(addr_valid_i));

   p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_o && warn_o) |-> (steer_o && group_o == '0 && inst_o == '0));

   p_implicit_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_o && !steer_o) |-> (!warn_o && group_o == '0 && inst_o == '0));

   p_fabric_double_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgt_ok[SK_FABRIC] |->
         (tgt_grp[SK_FABRIC*GRP_W +: GRP_W] == GRP_W'({tgt_grp[SK_MSLICE*GRP_W +: GRP_W], 1'b0})));

   p_bank_choice_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgt_ok[SK_L3BANK] |->
         (tgt_inst[SK_L3BANK*INST_W +: INST_W] == INST_W'(0) ||
          tgt_inst[SK_L3BANK*INST_W +: INST_W] == INST_W'(2)));

endmodule

// File: tb/repl_steer_lookup_tb.sv
module repl_steer_lookup_tb;

   localparam int unsigned ADDR_W = 24;
   localparam int unsigned RNG_N  = 4;
   localparam int unsigned IMP_N  = 4;
   localparam int unsigned NK     = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_valid = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [NK*RNG_N*ADDR_W-1:0] cfg_s = '0, cfg_e = '0;
   logic [IMP_N*ADDR_W-1:0]    imp_s = '0, imp_e = '0;
   logic [3:0]  msl_en  = 4'b0100;
   logic [2:0]  bank_m  = 3'b010;
   logic [15:0] sub_en  = 16'h0020;
   logic [7:0]  node_en = 8'b0010_0000;
   logic        res_valid, steer, warn;
   logic [3:0]  grp, inst;

   always #5 clk = ~clk;

   repl_steer_lookup u_dut (
      .clk_i(clk), .rst_ni(rst_n), .addr_valid_i(addr_valid), .addr_i(addr),
      .cfg_start_i(cfg_s), .cfg_end_i(cfg_e), .imp_start_i(imp_s), .imp_end_i(imp_e),
      .mslice_en_i(msl_en), .bank_mask_i(bank_m), .sub_en_i(sub_en), .node_en_i(node_en),
      .res_valid_o(res_valid), .steer_o(steer), .group_o(grp), .inst_o(inst), .warn_o(warn)
   );

   typedef struct packed {
      logic [ADDR_W-1:0] a;
      logic              s;
      logic [3:0]        g;
      logic [3:0]        i;
      logic              w;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    errors = 0;
   logic  prev_v = 1'b0;
   bit    done = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic set_win(input int k, input int e, input logic [ADDR_W-1:0] s,
                          input logic [ADDR_W-1:0] en);
      cfg_s[((k*RNG_N)+e)*ADDR_W +: ADDR_W] = s;
      cfg_e[((k*RNG_N)+e)*ADDR_W +: ADDR_W] = en;
   endtask

   task automatic set_imp(input int e, input logic [ADDR_W-1:0] s,
                          input logic [ADDR_W-1:0] en);
      imp_s[e*ADDR_W +: ADDR_W] = s;
      imp_e[e*ADDR_W +: ADDR_W] = en;
   endtask

   // Driver: one strobe per call; consecutive calls strobe back to back.
   task automatic issue(input logic [ADDR_W-1:0] a, input logic s, input logic [3:0] g,
                        input logic [3:0] i, input logic w, input string tag);
      exp_t x;
      @(posedge clk);
      #1;
      x.a = a; x.s = s; x.g = g; x.i = i; x.w = w;
      exp_q.push_back(x);
      tag_q.push_back(tag);
      addr = a;
      addr_valid = 1'b1;
   endtask

   task automatic idle(input int n);
      @(posedge clk);
      #1;
      addr_valid = 1'b0;
      repeat (n) @(posedge clk);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (prev_v != res_valid)
            check(1'b0, "R2", "result timing", {31'd0, res_valid}, {31'd0, prev_v});
         if (res_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", "unexpected result", 32'd1, 32'd0);
            end else begin
               exp_t  x;
               string t;
               x = exp_q.pop_front();
               t = tag_q.pop_front();
               check(steer == x.s, t, $sformatf("steer @%0h", x.a), {31'd0, steer}, {31'd0, x.s});
               check(grp == x.g,   t, $sformatf("group @%0h", x.a), {28'd0, grp},   {28'd0, x.g});
               check(inst == x.i,  t, $sformatf("inst @%0h", x.a),  {28'd0, inst},  {28'd0, x.i});
               check(warn == x.w,  t, $sformatf("warn @%0h", x.a),  {31'd0, warn},  {31'd0, x.w});
            end
         end
         prev_v = addr_valid;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      // kind 0 l3-bank: one window, then a zero-end terminator, then a dead window (R4)
      set_win(0, 0, 24'h001000, 24'h0010FF);
      set_win(0, 1, 24'h000000, 24'h000000);
      set_win(0, 2, 24'h009000, 24'h0090FF);
      // kind 1 memory slice: overlaps kind 0 at 0x1080..0x10FF (R5)
      set_win(1, 0, 24'h002000, 24'h0020FF);
      set_win(1, 1, 24'h001080, 24'h0010FF);
      // kind 2 cache fabric
      set_win(2, 0, 24'h003000, 24'h0030FF);
      // kind 3 subslice: a single-address window too (R3)
      set_win(3, 0, 24'h004000, 24'h0040FF);
      set_win(3, 1, 24'h005000, 24'h005000);
      // kind 4 node
      set_win(4, 0, 24'h006000, 24'h0060FF);
      // implicit list; second entry overlaps kind 2 (R7)
      set_imp(0, 24'h007000, 24'h0070FF);
      set_imp(1, 24'h003000, 24'h0030FF);

      repeat (3) @(negedge clk);
      // R1: reset state
      check(res_valid == 1'b0, "R1", "res_valid in reset", {31'd0, res_valid}, 0);
      check(steer == 1'b0 && warn == 1'b0, "R1", "flags in reset", {30'd0, steer, warn}, 0);
      check(grp == 4'd0 && inst == 4'd0, "R1", "target in reset", {24'd0, grp, inst}, 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(res_valid == 1'b0 && warn == 1'b0, "R1", "after reset release",
            {30'd0, res_valid, warn}, 0);

      // masks: mslice idx 2, bank bit0 clear, subslice idx 5, node idx 5
      issue(24'h001000, 1, 4'd2, 4'd2, 0, "R3 R12 low bound");
      issue(24'h0010FF, 1, 4'd2, 4'd2, 0, "R3 R5 high bound overlap");
      issue(24'h000FFF, 1, 4'd0, 4'd0, 1, "R3 R8 below window");
      issue(24'h001100, 1, 4'd0, 4'd0, 1, "R3 R8 above window");
      idle(2);
      issue(24'h001090, 1, 4'd2, 4'd2, 0, "R5 lowest kind wins");
      idle(1);
      issue(24'h009010, 1, 4'd0, 4'd0, 1, "R4 window after terminator");
      issue(24'h002010, 1, 4'd2, 4'd0, 0, "R11 memory slice");
      issue(24'h003010, 1, 4'd4, 4'd0, 0, "R7 R11 fabric over implicit");
      issue(24'h004010, 1, 4'd1, 4'd1, 0, "R10 subslice idx5");
      issue(24'h005000, 1, 4'd1, 4'd1, 0, "R3 single address");
      issue(24'h005001, 1, 4'd0, 4'd0, 1, "R3 R8 next to single");
      issue(24'h006000, 1, 4'd2, 4'd1, 0, "R13 node idx5");
      issue(24'h007000, 0, 4'd0, 4'd0, 0, "R6 implicit low");
      issue(24'h0070FF, 0, 4'd0, 4'd0, 0, "R6 implicit high");
      issue(24'h007100, 1, 4'd0, 4'd0, 1, "R8 past implicit");
      idle(3);

      // new masks: mslice idx 0, bank bit0 set, subslice idx 11, node idx 6
      msl_en  = 4'b1001;
      bank_m  = 3'b011;
      sub_en  = 16'h0800;
      node_en = 8'b0100_0000;
      issue(24'h001020, 1, 4'd0, 4'd0, 0, "R12 bank0 present");
      issue(24'h003020, 1, 4'd0, 4'd0, 0, "R11 fabric idx0");
      issue(24'h0040FF, 1, 4'd2, 4'd3, 0, "R10 subslice idx11");
      issue(24'h006080, 1, 4'd3, 4'd0, 0, "R13 node idx6");
      idle(3);

      msl_en = 4'b1000;
      issue(24'h003020, 1, 4'd6, 4'd0, 0, "R11 fabric idx3");
      idle(2);

      // R9: empty masks make kinds unusable
      sub_en = 16'h0000;
      msl_en = 4'b0000;
      issue(24'h004010, 1, 4'd0, 4'd0, 1, "R9 subslice unusable");
      issue(24'h003010, 0, 4'd0, 4'd0, 0, "R9 R6 fabric unusable falls to implicit");
      issue(24'h006010, 1, 4'd3, 4'd0, 0, "R9 node still usable");
      idle(4);

      check(exp_q.size() == 0, "R2", "results outstanding", exp_q.size(), 0);
      finish_run();
   end

endmodule